// File: doc/BRIEF.md
# SMBus Byte-Register Slave

This block is an SMBus slave that lets a host read and write a bank of eight 8-bit registers held outside the block. It watches the oversampled SCL and SDA lines and recognises START, repeated START and STOP conditions. It answers one 7-bit address and pulls SDA low through an open-drain enable to acknowledge bytes and to return data.

The host sets a command pointer with a Write Byte or a Read Byte, and a Receive Byte reads back the register that this pointer selects. The three low address bits come from strap pins. They are latched once, when reset is released, so several identical slaves can share one bus. The register file is reached through one address output driven by the pointer, a one-cycle write strobe with its data, and a read-data input that the register file answers combinationally.

Top module: `smbus_regbank_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal binary 1000 followed by the latched strap value, taken as strap_i[2] down to strap_i[0]. It does this by driving SDA low during the ninth clock. Bit 0 of the address byte is the direction: 0 means write and 1 means read.
- R2: For an address byte that does not match, the slave never drives SDA until the next START.
- R3: The strap value is captured in the first clock after reset is released and is never sampled again. A later change on strap_i does not change the address the slave answers.
- R4: Write Byte (address with write bit, command, data) acknowledges all three bytes and writes the data byte into the register that the command selects.
- R5: Read Byte (address with write bit, command, repeated START, address with read bit) returns the selected register, most significant bit first.
- R6: Receive Byte (address with read bit alone) returns the register selected by the last valid command byte. After reset the pointer selects register 0.
- R7: A command byte is valid only from 00h to 07h, and its low three bits select the register. Any other value is not acknowledged and changes neither the pointer nor any register.
- R8: The SDA output enable changes only while SCL is low.
- R9: After the eighth data bit of a read, the slave releases SDA and keeps it released until the next START or STOP, whether the host answers with ACK or NACK.
- R10: Each accepted Write Byte produces exactly one write strobe, one clock long. A reserved command, a read, or a non-matching address produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset (standby power good) |
| scl_i | input | 1 | SMBus clock line |
| sda_i | input | 1 | SMBus data line, as seen on the wire |
| sda_oe_o | output | 1 | High pulls SDA low (open drain) |
| strap_i | input | 3 | Address strap pins, latched once after reset |
| reg_addr_o | output | 3 | Register index from the command pointer |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Data to write |
| reg_rdata_i | input | 8 | Register contents at reg_addr_o |

## Verification
Random mixes of Write Byte, Read Byte, Receive Byte and transactions to a wrong address are run against a bench model of the pointer and the register contents. Each read shows whether the pointer was taken from the right command byte and whether the data order is right. Reserved commands followed by a Receive Byte show that the pointer did not move. Changing the straps after reset shows whether they are latched once or followed live. Clocking extra bits after a read shows whether the slave keeps SDA released, and a monitor of the write strobe and of SDA changes against SCL covers the single-strobe and SCL-low rules.

// File: rtl/smbus_slv_pkg.sv
package smbus_slv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK_SET, ST_ACK_HOLD, ST_TX, ST_WAIT
  } st_e;

  typedef enum logic [1:0] {
    K_ADDR, K_CMD, K_DATA
  } kind_e;
endpackage

// File: rtl/smbus_line_cond.sv
module smbus_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_d, sda_d;

  // idle bus reads high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_d    <= scl_sync[SYNC_STAGES-1];
      sda_d    <= sda_sync[SYNC_STAGES-1];
    end
  end

  logic scl_s, sda_s;
  assign scl_s      = scl_sync[SYNC_STAGES-1];
  assign sda_s      = sda_sync[SYNC_STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smbus_strap_latch.sv
module smbus_strap_latch #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] strap_i,
  output logic [W-1:0] strap_o,
  output logic         vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_o <= '0;
      vld_o   <= 1'b0;
    end else if (!vld_o) begin
      strap_o <= strap_i;
      vld_o   <= 1'b1;
    end
  end
endmodule

// File: rtl/smbus_proto_fsm.sv
module smbus_proto_fsm
  import smbus_slv_pkg::*;
#(
  parameter int           STRAP_W = 3,
  parameter int           AW      = 3,
  parameter int           DW      = 8,
  parameter logic [6-STRAP_W:0] ADDR_HI = 4'b1000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sda_i,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_oe_o,
  output logic [AW-1:0]      ptr_o,
  output logic               we_o,
  output logic [DW-1:0]      wdata_o,
  input  logic [DW-1:0]      rdata_i
);
  localparam int CW = $clog2(DW);

  st_e            st;
  kind_e          kind;
  logic [CW-1:0]  cnt;
  logic [DW-1:0]  sh;
  logic           ack_q, rd_q;
  logic [DW-1:0]  rx_byte;
  logic           addr_hit, cmd_ok;

  assign rx_byte  = {sh[DW-2:0], sda_i};
  assign addr_hit = rx_byte[7:1] == {ADDR_HI, strap_i};
  assign cmd_ok   = rx_byte[DW-1:AW] == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= ST_IDLE;
      kind     <= K_ADDR;
      cnt      <= '0;
      sh       <= '0;
      ack_q    <= 1'b0;
      rd_q     <= 1'b0;
      ptr_o    <= '0;
      sda_oe_o <= 1'b0;
      we_o     <= 1'b0;
      wdata_o  <= '0;
    end else begin
      we_o <= 1'b0;
      if (start_i) begin
        st       <= ST_RX;
        kind     <= K_ADDR;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        st       <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (st)
          ST_RX: if (scl_rise_i) begin
            sh  <= rx_byte;
            cnt <= cnt + 1'b1;
            if (cnt == CW'(DW-1)) begin
              st <= ST_ACK_SET;
              unique case (kind)
                K_ADDR: begin
                  ack_q <= addr_hit;
                  rd_q  <= rx_byte[0];
                end
                K_CMD: begin
                  ack_q <= cmd_ok;
                  if (cmd_ok) ptr_o <= rx_byte[AW-1:0];
                end
                default: begin
                  ack_q   <= 1'b1;
                  we_o    <= 1'b1;
                  wdata_o <= rx_byte;
                end
              endcase
            end
          end
          ST_ACK_SET: if (scl_fall_i) begin
            if (ack_q) begin
              sda_oe_o <= 1'b1;
              st       <= ST_ACK_HOLD;
            end else begin
              st <= ST_WAIT;
            end
          end
          ST_ACK_HOLD: if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            cnt      <= '0;
            if (kind == K_ADDR && rd_q) begin
              st       <= ST_TX;
              sh       <= rdata_i;
              sda_oe_o <= ~rdata_i[DW-1];
            end else if (kind == K_ADDR) begin
              kind <= K_CMD;
              st   <= ST_RX;
            end else if (kind == K_CMD) begin
              kind <= K_DATA;
              st   <= ST_RX;
            end else begin
              st <= ST_WAIT;
            end
          end
          ST_TX: if (scl_fall_i) begin
            if (cnt == CW'(DW-1)) begin
              sda_oe_o <= 1'b0;
              st       <= ST_WAIT;
            end else begin
              cnt      <= cnt + 1'b1;
              sh       <= sh << 1;
              sda_oe_o <= ~sh[DW-2];
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smbus_regbank_slave.sv
module smbus_regbank_slave #(
  parameter int SYNC_STAGES = 2,
  parameter int STRAP_W     = 3,
  parameter int AW          = 3,
  parameter int DW          = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [AW-1:0]      reg_addr_o,
  output logic               reg_we_o,
  output logic [DW-1:0]      reg_wdata_o,
  input  logic [DW-1:0]      reg_rdata_i
);
  logic sda_s, scl_rise, scl_fall, start, stop;
  logic [STRAP_W-1:0] strap_q;
  logic strap_vld;

  smbus_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  smbus_strap_latch #(.W(STRAP_W)) u_strap (
    .clk_i, .rst_ni, .strap_i, .strap_o(strap_q), .vld_o(strap_vld)
  );

  smbus_proto_fsm #(.STRAP_W(STRAP_W), .AW(AW), .DW(DW)) u_fsm (
    .clk_i, .rst_ni, .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start), .stop_i(stop), .strap_i(strap_q),
    .sda_oe_o, .ptr_o(reg_addr_o), .we_o(reg_we_o),
    .wdata_o(reg_wdata_o), .rdata_i(reg_rdata_i)
  );
endmodule

// File: rtl/smbus_slv_checker.sv
module smbus_slv_checker #(
  parameter int STRAP_W = 3,
  parameter int AW      = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               scl_i,
  input logic               sda_oe_o,
  input logic               reg_we_o,
  input logic [AW-1:0]      reg_addr_o,
  input logic [STRAP_W-1:0] strap_q,
  input logic               strap_vld
);
  a_r8_oe_moves_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

  a_r10_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  a_r4_strobe_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> scl_i);

  a_r3_strap_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(strap_vld) |-> $stable(strap_q));

  a_r7_ptr_moves_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_o != $past(reg_addr_o)) |-> scl_i);
endmodule

bind smbus_regbank_slave smbus_slv_checker #(.STRAP_W(STRAP_W), .AW(AW)) u_chk (
  .clk_i, .rst_ni, .scl_i, .sda_oe_o, .reg_we_o, .reg_addr_o,
  .strap_q(strap_q), .strap_vld(strap_vld)
);

// File: tb/tb_smbus_regbank_slave.sv
module tb_smbus_regbank_slave;
  localparam int Q = 8;
  localparam logic [2:0] STRAP0 = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_h = 1'b1;
  logic sda_oe;
  logic [2:0] strap = STRAP0;
  logic [2:0] raddr;
  logic we;
  logic [7:0] wdata, rdata;
  logic [7:0] regs [8];
  logic sda_bus;

  int checks = 0, errors = 0, we_cnt = 0, scl_viol = 0;
  logic [7:0] exp_regs [8];
  logic [2:0] exp_ptr = '0;

  always #5 clk = ~clk;
  assign sda_bus = sda_h & ~sda_oe;
  assign rdata   = regs[raddr];

  smbus_regbank_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .strap_i(strap), .reg_addr_o(raddr),
    .reg_we_o(we), .reg_wdata_o(wdata), .reg_rdata_i(rdata)
  );

  logic oe_d = 1'b0;
  always @(posedge clk) begin
    if (we) begin
      regs[raddr] <= wdata;
      we_cnt <= we_cnt + 1;
    end
    if (rst_n && sda_oe != oe_d && scl) scl_viol <= scl_viol + 1;
    oe_d <= sda_oe;
  end

  function automatic logic addr_ok(input logic [6:0] a);
    return a == {4'b1000, STRAP0};
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic t_start();
    sda_h = 1'b1; wq(); scl = 1'b1; wq(); sda_h = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic t_stop();
    sda_h = 1'b0; wq(); scl = 1'b1; wq(); sda_h = 1'b1; wq();
  endtask

  task automatic t_bit(input logic b, output logic r);
    sda_h = b; wq(); scl = 1'b1; wq(); r = sda_bus; wq(); scl = 1'b0; wq();
  endtask

  task automatic t_wbyte(input logic [7:0] v, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) t_bit(v[i], r);
    t_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic t_rbyte(input logic host_ack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      t_bit(1'b1, r);
      v[i] = r;
    end
    t_bit(~host_ack, r);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] cmd, input logic [7:0] d);
    logic ack;
    int w0;
    w0 = we_cnt;
    t_start();
    t_wbyte({a, 1'b0}, ack);
    chk(ack == addr_ok(a), "R1/R2 write addr ack", ack, addr_ok(a));
    if (ack) begin
      t_wbyte(cmd, ack);
      chk(ack == (cmd < 8), "R7 cmd ack", ack, cmd < 8);
      if (ack) begin
        exp_ptr = cmd[2:0];
        t_wbyte(d, ack);
        chk(ack, "R4 data ack", ack, 1);
        exp_regs[cmd[2:0]] = d;
      end
    end
    t_stop();
    chk(we_cnt - w0 == ((addr_ok(a) && cmd < 8) ? 1 : 0), "R10 strobe count",
        we_cnt - w0, (addr_ok(a) && cmd < 8) ? 1 : 0);
  endtask

  task automatic do_readbyte(input logic [7:0] cmd);
    logic ack;
    logic [7:0] v;
    t_start();
    t_wbyte({4'b1000, STRAP0, 1'b0}, ack);
    t_wbyte(cmd, ack);
    chk(ack == (cmd < 8), "R7 read cmd ack", ack, cmd < 8);
    if (ack) exp_ptr = cmd[2:0];
    t_start();
    t_wbyte({4'b1000, STRAP0, 1'b1}, ack);
    chk(ack, "R1 read addr ack", ack, 1);
    t_rbyte(1'b0, v);
    chk(v == exp_regs[exp_ptr], "R5 read byte data", v, exp_regs[exp_ptr]);
    t_stop();
  endtask

  task automatic do_receive(input logic host_ack, input logic extra);
    logic ack, r;
    logic [7:0] v;
    t_start();
    t_wbyte({4'b1000, STRAP0, 1'b1}, ack);
    chk(ack, "R6 recv addr ack", ack, 1);
    t_rbyte(host_ack, v);
    chk(v == exp_regs[exp_ptr], "R6 receive data", v, exp_regs[exp_ptr]);
    if (extra) begin
      v = '0;
      for (int i = 0; i < 9; i++) begin
        t_bit(1'b1, r);
        v = {v[6:0], r};
      end
      chk(v == 8'hFF && r, "R9 released after read", v, 8'hFF);
    end
    t_stop();
  endtask

  task automatic do_badaddr(input logic [6:0] a, input logic rw);
    logic ack, r;
    int low = 0;
    t_start();
    t_wbyte({a, rw}, ack);
    chk(!ack, "R2 no ack wrong addr", ack, 0);
    for (int i = 0; i < 9; i++) begin
      t_bit(1'b1, r);
      if (!r) low++;
    end
    chk(low == 0, "R2 sda untouched", low, 0);
    t_stop();
  endtask

  initial begin
    int seed;
    logic [7:0] c, d;
    logic [6:0] a;
    seed = 1234;
    void'($urandom(seed));
    for (int i = 0; i < 8; i++) begin
      regs[i] = 8'h00;
      exp_regs[i] = 8'h00;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    strap = 3'b010;  // R3: must be ignored from now on
    chk(sda_oe == 1'b0 && raddr == 3'd0 && we == 1'b0, "R6 reset state", {sda_oe, raddr, we}, 0);
    wq();

    do_receive(1'b0, 1'b0);
    do_write({4'b1000, STRAP0}, 8'h03, 8'hA5);
    chk(regs[3] == 8'hA5, "R4 reg written", regs[3], 8'hA5);
    do_readbyte(8'h03);
    do_write({4'b1000, 3'b010}, 8'h01, 8'h77);  // R3: live strap value must not match
    do_badaddr({4'b1000, 3'b010}, 1'b1);
    do_write({4'b1000, STRAP0}, 8'h07, 8'h81);
    do_write({4'b1000, STRAP0}, 8'h08, 8'h55);  // R7 reserved
    do_receive(1'b1, 1'b1);                     // pointer still 7
    do_write({4'b1000, STRAP0}, 8'hF2, 8'h11);
    do_receive(1'b0, 1'b1);
    do_write({4'b1000, STRAP0}, 8'h00, 8'h80);
    do_readbyte(8'h00);
    do_readbyte(8'h40);

    for (int n = 0; n < 40; n++) begin
      c = 8'($urandom_range(0, 3) == 0 ? $urandom : $urandom_range(0, 7));
      d = 8'($urandom);
      case ($urandom_range(0, 3))
        0: do_write({4'b1000, STRAP0}, c, d);
        1: do_readbyte(c);
        2: do_receive(1'($urandom), 1'($urandom));
        default: begin
          a = 7'($urandom);
          if (!addr_ok(a)) do_badaddr(a, 1'($urandom));
        end
      endcase
    end

    chk(scl_viol == 0, "R8 sda changes with scl low", scl_viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule